// File: doc/BRIEF.md
# Configuration Stream Sync and Identity Checker

This block sits at the front of a configuration loader. It takes a stream of 32-bit words, each qualified by a valid strobe and captured on the rising clock edge. It ignores everything until it meets one fixed marker word. The word right after the marker carries a device identity. That identity is compared, with a mask, against an expected value. Only when the identity matches does the block start to pass payload words on.

Payload is cut into frames of a fixed, parameterised length. The last word of each frame holds a CRC-32 over the words before it. On a good frame the block pulses a completion flag. A bad identity sets a sticky error bit, and a bad CRC gives a one-cycle error pulse. Either error freezes the block until a synchronous clear or a reset returns it to the marker search.

Top module: `bitstream_sync_check`

## Requirements
- R1: After reset, or one cycle after `clr` is sampled high, `synced`, `id_err`, `pld_vld`, `crc_err` and `frame_done` are all 0.
- R2: While hunting, every accepted word other than exactly 0xAA995566 is discarded. A word that differs from it in any bit keeps `synced` at 0 and produces no payload.
- R3: `synced` goes to 1 in the cycle after the marker word 0xAA995566 is accepted, and stays 1 until `clr` or reset.
- R4: The first accepted word after the marker is the identity. Bits [31:4] are features and are compared with `exp_id[27:0]`. Bits [3:0] are a mask: a set bit k makes feature bit k (word bit 4+k) a don't-care. If the compare passes, loading is enabled.
- R5: On an identity mismatch, `id_err` is 1 from the next cycle on and stays set until `clr` or reset. No payload is forwarded while it is set.
- R6: In loading, the first FRAME_LEN-1 accepted words of each frame appear on `pld_data`, with `pld_vld` high for one cycle, one cycle after they are accepted. The CRC word is not forwarded.
- R7: The CRC is CRC-32 with polynomial 0x04C11DB7. It starts at 0xFFFFFFFF, takes data bits MSB first, uses no reflection and no final inversion, and covers the data words of one frame. When the FRAME_LEN-th word equals the CRC, `frame_done` pulses for one cycle, one cycle later, and the CRC restarts for the next frame.
- R8: When the CRC word does not match, `crc_err` pulses for one cycle, one cycle later. After that, every accepted word is ignored until `clr` or reset.
- R9: A cycle with `word_vld` low changes no state and produces no output pulse.
- R10: `clr` acts at the clock edge, takes priority over a word presented in the same cycle, and returns the block to the hunt with a fresh frame count and CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous return to hunt |
| word_vld | input | 1 | Qualifies `word_in` this cycle |
| word_in | input | 32 | Stream word |
| exp_id | input | 28 | Expected identity features |
| synced | output | 1 | Marker found |
| pld_vld | output | 1 | Payload word valid |
| pld_data | output | 32 | Forwarded payload word |
| id_err | output | 1 | Sticky identity mismatch |
| crc_err | output | 1 | One-cycle CRC mismatch pulse |
| frame_done | output | 1 | One-cycle good-frame pulse |

## Verification
Every result appears exactly one clock after the word or clear that causes it. This covers the rise of `synced`, the setting of `id_err`, each payload beat, and the `frame_done` or `crc_err` pulse. The bench drives inputs at the falling edge and advances a behavioural model by one step. At the following falling edge it compares all outputs with that prediction, so each check samples the one cycle in which the result is due.

// File: rtl/bitstream_sync_check.sv
module bitstream_sync_check #(
  parameter int          FRAME_LEN = 4,
  parameter logic [31:0] SYNC_WORD = 32'hAA995566,
  parameter logic [31:0] CRC_POLY  = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        word_vld,
  input  logic [31:0] word_in,
  input  logic [27:0] exp_id,
  output logic        synced,
  output logic        pld_vld,
  output logic [31:0] pld_data,
  output logic        id_err,
  output logic        crc_err,
  output logic        frame_done
);
  localparam int CW = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  typedef enum logic [1:0] {HUNT, IDCHK, LOAD, HALT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [31:0]   crc;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  wire [27:0] care  = ~{24'h0, word_in[3:0]};
  wire        id_ok = ((word_in[31:4] ^ exp_id) & care) == 28'h0;
  wire        last  = (cnt == LAST);

  assign synced = (st != HUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= HUNT;
      cnt        <= '0;
      crc        <= CRC_INIT;
      id_err     <= 1'b0;
      pld_vld    <= 1'b0;
      pld_data   <= '0;
      crc_err    <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      pld_vld    <= 1'b0;
      crc_err    <= 1'b0;
      frame_done <= 1'b0;
      if (clr) begin
        st     <= HUNT;
        cnt    <= '0;
        crc    <= CRC_INIT;
        id_err <= 1'b0;
      end else if (word_vld) begin
        case (st)
          HUNT:  if (word_in == SYNC_WORD) st <= IDCHK;
          IDCHK: begin
            if (id_ok) st <= LOAD;
            else begin
              st     <= HALT;
              id_err <= 1'b1;
            end
          end
          LOAD: begin
            if (!last) begin
              pld_vld  <= 1'b1;
              pld_data <= word_in;
              crc      <= crc_step(crc, word_in);
              cnt      <= cnt + 1'b1;
            end else begin
              if (crc == word_in) frame_done <= 1'b1;
              else begin
                crc_err <= 1'b1;
                st      <= HALT;
              end
              crc <= CRC_INIT;
              cnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bitstream_sync_check_chk.sv
module bitstream_sync_check_chk #(
  parameter logic [31:0] SYNC_WORD = 32'hAA995566
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        word_vld,
  input logic [31:0] word_in,
  input logic        synced,
  input logic        pld_vld,
  input logic        id_err,
  input logic        crc_err,
  input logic        frame_done
);
  assert_sync_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced) |-> $past(word_vld && !clr && word_in == SYNC_WORD));

  assert_pld_needs_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pld_vld |-> synced);

  assert_iderr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_err && !clr) |=> id_err);

  assert_no_pld_on_iderr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |-> !pld_vld);

  assert_crcerr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> (!crc_err && !pld_vld && !frame_done));

  assert_done_vs_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_err && frame_done));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!synced && !id_err && !pld_vld && !crc_err && !frame_done));

  assert_gap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> (!pld_vld && !crc_err && !frame_done));
endmodule

bind bitstream_sync_check bitstream_sync_check_chk #(.SYNC_WORD(SYNC_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .word_vld(word_vld), .word_in(word_in),
  .synced(synced), .pld_vld(pld_vld), .id_err(id_err), .crc_err(crc_err),
  .frame_done(frame_done)
);

// File: tb/bitstream_sync_check_tb.sv
`timescale 1ns/1ps
module bitstream_sync_check_tb;
  localparam int FL = 4;
  localparam logic [31:0] SYNC = 32'hAA995566;

  logic clk = 0, rst_n = 0, clr = 0, word_vld = 0;
  logic [31:0] word_in = '0;
  logic [27:0] exp_id = 28'h1234567;
  logic synced, pld_vld, id_err, crc_err, frame_done;
  logic [31:0] pld_data;

  always #4 clk = ~clk;

  bitstream_sync_check #(.FRAME_LEN(FL)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .word_vld(word_vld), .word_in(word_in),
    .exp_id(exp_id), .synced(synced), .pld_vld(pld_vld), .pld_data(pld_data),
    .id_err(id_err), .crc_err(crc_err), .frame_done(frame_done));

  int total = 0, bad = 0;
  string phase = "R1";

  int m_state = 0, m_cnt = 0;
  bit [31:0] m_crc = 32'hFFFFFFFF;
  bit e_synced = 0, e_iderr = 0, e_pld = 0, e_fd = 0, e_ce = 0;
  bit [31:0] e_data = 0;

  function automatic bit [31:0] crc_ref(bit [31:0] c, bit [31:0] d);
    bit [31:0] r = c;
    for (int k = 0; k < 32; k++) begin
      bit fb = r[31] ^ d[31-k];
      r = r << 1;
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic bit id_match(bit [31:0] w, bit [27:0] e);
    for (int i = 4; i < 32; i++) begin
      bit dc = (i < 8) && w[i-4];
      if (!dc && (w[i] != e[i-4])) return 0;
    end
    return 1;
  endfunction

  task automatic chk1(string nm, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", phase, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk1("synced R3", 32'(synced), 32'(e_synced));
    chk1("id_err R5", 32'(id_err), 32'(e_iderr));
    chk1("pld_vld R6", 32'(pld_vld), 32'(e_pld));
    chk1("frame_done R7", 32'(frame_done), 32'(e_fd));
    chk1("crc_err R8", 32'(crc_err), 32'(e_ce));
    if (e_pld) chk1("pld_data R6", pld_data, e_data);
  endtask

  task automatic model(bit v, bit [31:0] w, bit c);
    e_pld = 0; e_fd = 0; e_ce = 0;
    if (c) begin
      m_state = 0; m_cnt = 0; m_crc = 32'hFFFFFFFF; e_iderr = 0;
    end else if (v) begin
      if (m_state == 0) begin
        if (w == SYNC) m_state = 1;
      end else if (m_state == 1) begin
        if (id_match(w, exp_id)) m_state = 2;
        else begin m_state = 3; e_iderr = 1; end
      end else if (m_state == 2) begin
        if (m_cnt < FL-1) begin
          e_pld = 1; e_data = w; m_crc = crc_ref(m_crc, w); m_cnt++;
        end else begin
          if (m_crc == w) e_fd = 1;
          else begin e_ce = 1; m_state = 3; end
          m_cnt = 0; m_crc = 32'hFFFFFFFF;
        end
      end
    end
    e_synced = (m_state != 0);
  endtask

  task automatic cyc(bit v, bit [31:0] w, bit c);
    @(negedge clk);
    compare();
    word_vld = v; word_in = w; clr = c;
    model(v, w, c);
  endtask

  task automatic put(bit [31:0] w); cyc(1, w, 0); endtask
  task automatic idle(); cyc(0, 32'hDEADBEEF, 0); endtask
  task automatic clear(); cyc(1, SYNC, 1); endtask

  task automatic frame(bit [31:0] a, bit [31:0] b, bit [31:0] d, bit good);
    bit [31:0] c = crc_ref(crc_ref(crc_ref(32'hFFFFFFFF, a), b), d);
    put(a); put(b); put(d);
    put(good ? c : c ^ 32'h1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    idle(); idle();
    phase = "R2";
    put(32'h12345678); put(SYNC ^ 32'h1); put(32'h5566AA99); put(SYNC ^ 32'h80000000);
    phase = "R3";
    put(SYNC); idle();
    phase = "R9";
    idle(); idle();
    phase = "R4";
    put({28'h123456F, 4'h8});
    phase = "R6";
    frame(32'h00000001, 32'hCAFEF00D, SYNC, 1);
    phase = "R9";
    put(32'hA5A5A5A5); idle(); put(32'h0F0F0F0F); idle();
    phase = "R7";
    put(32'h11111111);
    begin
      bit [31:0] c = crc_ref(crc_ref(crc_ref(32'hFFFFFFFF, 32'hA5A5A5A5), 32'h0F0F0F0F), 32'h11111111);
      put(c);
    end
    frame(32'h0, 32'h0, 32'h0, 1);
    phase = "R8";
    frame(32'h01234567, 32'h89ABCDEF, 32'h76543210, 0);
    put(SYNC); put(32'h22222222); idle();
    phase = "R10";
    clear(); idle();
    phase = "R5";
    put(SYNC); put({28'h123456F, 4'h7});
    put(32'h33333333); put(SYNC); idle();
    phase = "R10";
    clear();
    phase = "R4";
    put(SYNC); put({28'h1234560, 4'h7});
    put(32'h44444444); put(32'h55555555);
    phase = "R10";
    clear(); put(SYNC); put({28'h1234567, 4'h0});
    frame(32'h66666666, 32'h77777777, 32'h88888888, 1);
    frame(32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 1);
    idle(); idle();
    finish_run();
  end
endmodule